// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one general-purpose I/O port with a parameterised number of pins, 32 by default. Software reaches it through a plain single-cycle register interface: a word index, a write strobe with write data, and combinational read data. Software programs an output value and a per-pin direction. The block drives the pad outputs and output enables from them. Every pad input passes through a synchronizer, and the synchronized value can be read back.

Each pin watches its synchronized input for one trigger condition: low level, high level, rising edge or falling edge. A per-pin override makes the pin respond to any transition. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. A per-pin enable mask gates the status onto three interrupt lines: one for the lower half of the pins, one for the upper half, and one for all pins.

Register word indices (byte offset = 4 × index): 0 output value, 1 direction, 2 synchronized pad view (read-only), 3 trigger fields of the lower pin half, 4 trigger fields of the upper pin half, 5 enable mask, 6 sticky status, 7 any-transition override.

Top module: `gpio_port_irq`

## Requirements
- R1: While reset is low and directly after reset, every register reads 0 and pad_out, pad_oe, irq_lo, irq_hi and irq_any are 0. No event is recorded until the synchronizer pipeline has refilled, three clocks after reset is released.
- R2: Index 0 holds the value driven on pad_out and index 1 holds the direction; a direction bit of 1 sets that pin's pad_oe bit. Both registers read back what was written, and pad_out shows a write on the clock after it.
- R3: Index 2 reads pad_in through a two-flop synchronizer: a change in pad_in is not yet visible after one clock edge and is visible after two. Writes to index 2 have no effect.
- R4: The 2-bit trigger field of pin p sits at bits 2·(p mod HALF)+1:2·(p mod HALF), where HALF is half the pin count. It is in index 3 for pins below HALF and in index 4 for pins at HALF or above. Both registers read back what was written.
- R5: Trigger field codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. An edge is the synchronized value against its value one clock earlier. For an edge trigger, the status bit is 0 after the second clock edge following a pad change and is 1 after the third.
- R6: A level trigger sets its status bit on every clock its level holds, so the bit reads 1 again straight after a clear while the level persists.
- R7: A 1 in bit p of index 7 makes pin p flag both rising and falling edges and makes its trigger field, level codes included, have no effect.
- R8: Writing index 6 clears each status bit written with 1 and leaves bits written with 0 unchanged. A status bit never falls without such a write.
- R9: If a detection event and a clearing write hit the same status bit in one clock, the bit stays 1.
- R10: A status bit reaches the interrupt lines only when its bit in index 5 is 1. irq_lo is the OR of the enabled status of pins below HALF, irq_hi is the OR for the rest, and irq_any is the OR over all pins.
- R11: A pin configured as an output still detects events on its pad_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data of the indexed register, combinational |
| pad_in | input | NPINS | Pad input values, asynchronous |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for the lower pin half |
| irq_hi | output | 1 | Interrupt for the upper pin half |
| irq_any | output | 1 | Interrupt over all pins |

## Verification
The assertions take it that bus_we is held low during reset. They also take it that the reset pulse is long enough for the detection gate to close before any event can reach the status register. The bench holds the strobe low throughout reset. It changes pad_in and the bus signals only on falling clock edges, one pad bit at a time, and waits for the synchronizer to settle before it reads or clears status. In this way every sampled value falls at a known clock count after its stimulus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int REG_IDX_W = 3;

   localparam logic [REG_IDX_W-1:0] REG_DOUT   = 3'd0;
   localparam logic [REG_IDX_W-1:0] REG_DIR    = 3'd1;
   localparam logic [REG_IDX_W-1:0] REG_PAD    = 3'd2;
   localparam logic [REG_IDX_W-1:0] REG_CFG_LO = 3'd3;
   localparam logic [REG_IDX_W-1:0] REG_CFG_HI = 3'd4;
   localparam logic [REG_IDX_W-1:0] REG_MASK   = 3'd5;
   localparam logic [REG_IDX_W-1:0] REG_STAT   = 3'd6;
   localparam logic [REG_IDX_W-1:0] REG_BOTH   = 3'd7;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_port_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= d_async;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_detect.sv
module gpio_port_detect
   import gpio_port_pkg::*;
(
   input  logic       cur,
   input  logic       prev,
   input  logic [1:0] trig,
   input  logic       any_edge,
   output logic       hit
);
   logic rise, fall, cond;

   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   always_comb begin
      unique case (trig_e'(trig))
         TRIG_LOW:  cond = ~cur;
         TRIG_HIGH: cond = cur;
         TRIG_RISE: cond = rise;
         TRIG_FALL: cond = fall;
         default:   cond = 1'b0;
      endcase
   end

   assign hit = any_edge ? (rise | fall) : cond;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] idx,
   input  logic [NPINS-1:0]     wr_data,
   input  logic [NPINS-1:0]     evt,
   input  logic [NPINS-1:0]     pad_sync,
   output logic [NPINS-1:0]     dout_q,
   output logic [NPINS-1:0]     dir_q,
   output logic [NPINS-1:0]     cfg_lo_q,
   output logic [NPINS-1:0]     cfg_hi_q,
   output logic [NPINS-1:0]     mask_q,
   output logic [NPINS-1:0]     both_q,
   output logic [NPINS-1:0]     stat_q,
   output logic [NPINS-1:0]     rd_data
);
   logic             stat_wr;
   logic [NPINS-1:0] clr_bits;

   assign stat_wr  = wr_en && (idx == REG_STAT);
   assign clr_bits = stat_wr ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dir_q    <= '0;
         cfg_lo_q <= '0;
         cfg_hi_q <= '0;
         mask_q   <= '0;
         both_q   <= '0;
         stat_q   <= '0;
      end else begin
         if (wr_en) begin
            case (idx)
               REG_DOUT:   dout_q   <= wr_data;
               REG_DIR:    dir_q    <= wr_data;
               REG_CFG_LO: cfg_lo_q <= wr_data;
               REG_CFG_HI: cfg_hi_q <= wr_data;
               REG_MASK:   mask_q   <= wr_data;
               REG_BOTH:   both_q   <= wr_data;
               default: ;
            endcase
         end
         // an event in the same clock outranks the clear
         stat_q <= (stat_q & ~clr_bits) | evt;
      end
   end

   always_comb begin
      case (idx)
         REG_DOUT:   rd_data = dout_q;
         REG_DIR:    rd_data = dir_q;
         REG_PAD:    rd_data = pad_sync;
         REG_CFG_LO: rd_data = cfg_lo_q;
         REG_CFG_HI: rd_data = cfg_hi_q;
         REG_MASK:   rd_data = mask_q;
         REG_STAT:   rd_data = stat_q;
         REG_BOTH:   rd_data = both_q;
         default:    rd_data = '0;
      endcase
   end

   // R8: bits written with 1 and not re-flagged are gone next clock
   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((stat_q & $past(wr_data & ~evt)) == '0));

   // R8: without a clearing write no pending bit drops
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R9: every flagged event is pending next clock, clear or not
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_IDX_W-1:0] bus_addr,
   input  logic                 bus_we,
   input  logic [NPINS-1:0]     bus_wdata,
   output logic [NPINS-1:0]     bus_rdata,
   input  logic [NPINS-1:0]     pad_in,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_oe,
   output logic                 irq_lo,
   output logic                 irq_hi,
   output logic                 irq_any
);
   localparam int HALF    = NPINS / 2;
   localparam int PRIME_N = SYNC_STAGES + 1;
   localparam int PRIME_W = $clog2(PRIME_N + 1);

   if ((NPINS % 2) != 0 || NPINS < 2) begin : g_bad_npins
      $error("gpio_port_irq: NPINS must be even and at least 2");
   end

   logic [NPINS-1:0]   pad_sync, prev_q, raw_evt, evt;
   logic [NPINS-1:0]   dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q, stat_q;
   logic [NPINS-1:0]   armed;
   logic [PRIME_W-1:0] prime_cnt;
   logic               primed;

   gpio_port_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pad_in),
      .q_sync  (pad_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         prime_cnt <= '0;
      end else begin
         prev_q <= pad_sync;
         if (!primed) prime_cnt <= prime_cnt + 1'b1;
      end
   end

   assign primed = (prime_cnt == PRIME_W'(PRIME_N));

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [1:0] trig;
      if (i < HALF) begin : g_lo
         assign trig = cfg_lo_q[2*i +: 2];
      end else begin : g_hi
         assign trig = cfg_hi_q[2*(i-HALF) +: 2];
      end
      gpio_port_detect u_det (
         .cur      (pad_sync[i]),
         .prev     (prev_q[i]),
         .trig     (trig),
         .any_edge (both_q[i]),
         .hit      (raw_evt[i])
      );
   end

   assign evt = primed ? raw_evt : '0;

   gpio_port_regs #(.NPINS(NPINS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we),
      .idx      (bus_addr),
      .wr_data  (bus_wdata),
      .evt      (evt),
      .pad_sync (pad_sync),
      .dout_q   (dout_q),
      .dir_q    (dir_q),
      .cfg_lo_q (cfg_lo_q),
      .cfg_hi_q (cfg_hi_q),
      .mask_q   (mask_q),
      .both_q   (both_q),
      .stat_q   (stat_q),
      .rd_data  (bus_rdata)
   );

   assign pad_out = dout_q;
   assign pad_oe  = dir_q;
   assign armed   = stat_q & mask_q;
   assign irq_lo  = |armed[HALF-1:0];
   assign irq_hi  = |armed[NPINS-1:HALF];
   assign irq_any = |armed;

   // R2: a write to the output register reaches the pads next clock
   p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == REG_DOUT) |=> (pad_out == $past(bus_wdata)));

   // R7: any synchronized transition on an override pin becomes pending
   p_both_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (((pad_sync ^ prev_q) & both_q) != '0))
      |=> ((stat_q & $past((pad_sync ^ prev_q) & both_q))
           == $past((pad_sync ^ prev_q) & both_q)));
endmodule

// File: tb/tb_gpio_port_irq.sv
`timescale 1ns/1ps
module tb_gpio_port_irq;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic         bus_we = 1'b0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_out, pad_oe;
   logic         irq_lo, irq_hi, irq_any;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   gpio_port_irq #(.NPINS(N), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
      .irq_any(irq_any)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   // status bit of pin p plus irq lines; mask holds only pin p
   task automatic chk_pin(input string req, input int p, input logic e);
      logic [N-1:0] d;
      logic [3:0]   exp;
      rd(3'd6, d);
      exp = {e & (p < N/2), e & (p >= N/2), e, e};
      check(req, {irq_lo, irq_hi, irq_any, d[p]}, exp);
   endtask

   initial begin
      logic [N-1:0] d;
      // R1: reset state
      idle(3);
      for (int a = 0; a < 8; a++) begin
         if (a == 2) continue;
         bus_addr = 3'(a); #1;
         check("R1 reg", bus_rdata, 0);
      end
      check("R1 outputs", {pad_out, pad_oe, irq_lo, irq_hi, irq_any}, 0);
      @(negedge clk) rst_n = 1'b1;
      idle(6);

      // R2: output and direction
      wr(3'd0, 32'hA5C3_0F81);
      check("R2 pad_out", pad_out, 32'hA5C3_0F81);
      wr(3'd1, 32'h0FF0_1234);
      check("R2 pad_oe", pad_oe, 32'h0FF0_1234);
      rd(3'd0, d); check("R2 rd dout", d, 32'hA5C3_0F81);
      rd(3'd1, d); check("R2 rd dir", d, 32'h0FF0_1234);

      // R4: trigger config readback
      wr(3'd3, 32'h1234_5678); wr(3'd4, 32'h9ABC_DEF0);
      rd(3'd3, d); check("R4 cfg lo", d, 32'h1234_5678);
      rd(3'd4, d); check("R4 cfg hi", d, 32'h9ABC_DEF0);

      // R3: synchronizer latency and write ignored
      @(negedge clk) pad_in = 32'hDEAD_BEEF; bus_addr = 3'd2;
      @(posedge clk) #1 check("R3 one edge", bus_rdata, 0);
      @(posedge clk) #1 check("R3 two edges", bus_rdata, 32'hDEAD_BEEF);
      wr(3'd2, 32'h0);
      rd(3'd2, d); check("R3 write ignored", d, 32'hDEAD_BEEF);
      @(negedge clk) pad_in = '0;
      idle(4);

      // R5: exact latency for a rising edge on pin 3
      wr(3'd3, 32'(2'b10) << 6); wr(3'd4, 0); wr(3'd7, 0); wr(3'd5, 32'h8);
      wr(3'd6, '1);
      @(negedge clk) pad_in[3] = 1'b1; bus_addr = 3'd6;
      @(posedge clk); @(posedge clk) #1 check("R5 two edges", bus_rdata[3], 0);
      @(posedge clk) #1 check("R5 three edges", bus_rdata[3], 1);
      @(negedge clk) pad_in[3] = 1'b0;
      idle(4);

      // R8: partial clear leaves bits written with 0
      wr(3'd3, '1); wr(3'd4, '1);             // all falling, pads quiet
      @(negedge clk) pad_in = 32'h0001_0101; idle(4);
      @(negedge clk) pad_in = '0; idle(4);
      rd(3'd6, d); check("R8 flagged", d & 32'h0001_0101, 32'h0001_0101);
      wr(3'd6, 32'h0000_0100);
      rd(3'd6, d); check("R8 partial clear", d & 32'h0001_0101, 32'h0001_0001);
      idle(5);
      rd(3'd6, d); check("R8 sticky", d & 32'h0001_0101, 32'h0001_0001);
      // R10: unmasked status stays off the lines
      wr(3'd5, 32'h0000_0100);
      check("R10 masked off", {irq_lo, irq_hi, irq_any}, 0);
      wr(3'd5, 32'h0001_0000);
      check("R10 upper half", {irq_lo, irq_hi, irq_any}, 3'b011);
      wr(3'd6, '1);

      // sweep: every pin, every code, override off/on (override also sets outputs, R11)
      for (int p = 0; p < N; p++) begin
         for (int b = 0; b < 2; b++) begin
            for (int m = 0; m < 4; m++) begin
               logic [N-1:0] cfg;
               cfg = N'(m) << (2 * (p % (N/2)));
               wr(3'd3, (p < N/2) ? cfg : '0);
               wr(3'd4, (p < N/2) ? '0 : cfg);
               wr(3'd7, b ? (N'(1) << p) : '0);
               wr(3'd1, b ? '1 : '0);
               wr(3'd5, N'(1) << p);
               idle(4);
               wr(3'd6, '1);
               // R6/R9: low level re-flags in the clearing clock
               chk_pin("R6 R9 cleared low pad", p, (b == 0) && (m == 0));
               @(negedge clk) pad_in[p] = 1'b1; idle(4);
               chk_pin("R5 R7 R11 after rise", p, (b == 1) || (m != 3));
               wr(3'd6, '1);
               chk_pin("R6 cleared high pad", p, (b == 0) && (m == 1));
               @(negedge clk) pad_in[p] = 1'b0; idle(4);
               chk_pin("R5 R7 after fall", p, (b == 1) || (m != 2));
               wr(3'd6, '1);
               chk_pin("R6 R7 final clear", p, (b == 0) && (m == 0));
            end
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule